// File: doc/BRIEF.md
# Flux-Controlled Multistate Memristor Emulator

This block is a digital stand-in for a memristive device. Each accepted input sample is a signed Q16.16 value. The block keeps a running flux integral of the input: on every valid sample it adds the input scaled down by a power-of-two time step. It also produces the output as the input times a slope. The slope is the sum of a main coefficient `a` and a history coefficient `b`. The sign of `b` follows the sign bit of the flux register. Because the sign of `b` flips when the flux crosses zero, a periodic input traces a pinched loop in the output-versus-input plane. The block needs no nonlinear arithmetic to do this.

A mode input picks between two behaviours. In two-state mode only the first coefficient pair is used. In five-state mode, four flux thresholds divide the flux range into five bands. Each band has its own coefficient pair. The names "input" and "output" carry no units: the block models a voltage-driven device when the input is read as voltage and the output as current, and a current-driven device when the two are swapped.

A small write port loads the coefficients and thresholds. The block refuses any write that would leave a pair with |b| greater than |a|, and it flags the refusal.

Top module: `memristor_flux_emu`

## Requirements
- R1: After a synchronous active-low reset, `y_out` is 0, `y_valid` is 0, `cfg_err` is 0 and the flux is 0. Every `a` coefficient is 1.0 (0x00010000) and every `b` coefficient is 0. The thresholds are -1.5, -0.5, 0.5 and 1.5 (0xFFFE8000, 0xFFFF8000, 0x00008000, 0x00018000).
- R2: `y_valid` is high in exactly the cycle after each cycle in which `x_valid` is high. `y_out` changes only in that cycle and holds its value otherwise.
- R3: On each valid sample the flux becomes flux + (`x_in` >>> 4), using an arithmetic shift. When `x_valid` is low the flux is unchanged.
- R4: In two-state mode (`mode_five`=0), `y_out` = sat(( `x_in` × slope ) >>> 16), where slope = a0+b0 if the flux before this sample is non-negative (sign bit 0) and a0−b0 otherwise.
- R5: In five-state mode (`mode_five`=1), the band is the number of thresholds t_k with flux ≥ t_k, a value from 0 to 4. The slope is then a_band ± b_band, with the sign chosen by the same rule as in R4.
- R6: Write addresses decode as follows: 0–4 write a0–a4, 5–9 write b0–b4, and 10–13 write thresholds t0–t3. A write to any other address changes nothing and does not raise `cfg_err`.
- R7: Two kinds of write are rejected: writing b_k with |data| > |a_k|, and writing a_k with |data| < |b_k|. A rejected write leaves the register unchanged and raises `cfg_err` for exactly the next cycle. An accepted write, including one where |b| = |a|, leaves `cfg_err` low.
- R8: When the shifted product does not fit in a signed 32-bit value, `y_out` saturates to 0x7FFFFFFF or 0x80000000.
- R9: The flux saturates at 0x7FFFFFFF and 0x80000000 and never wraps around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_five | input | 1 | 0 = two-state, 1 = five-state band selection |
| x_valid | input | 1 | Input sample strobe |
| x_in | input | 32 | Signed Q16.16 input sample |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 32 | Signed Q16.16 configuration data |
| y_out | output | 32 | Signed Q16.16 output sample |
| y_valid | output | 1 | Output sample strobe |
| cfg_err | output | 1 | One-cycle pulse for a rejected write |

## Verification
An output sample is due one clock after its input strobe. The bench therefore drives a sample on a falling edge and checks `y_out` and `y_valid` on the next falling edge. It checks one falling edge after that to confirm that `y_valid` has dropped and `y_out` is held. `cfg_err` is likewise registered one clock after the write edge, so each write is checked on the following falling edge. The flux cannot be read directly. Its value, including saturation, is checked through the slope sign and band that later samples select, using a bench model that updates the flux only after computing each expected output.

// File: rtl/mfe_pkg.sv
// Shared definitions for the flux-controlled memristor emulator.
// Holds the configuration field decode used by the write port.
package mfe_pkg;

    typedef enum logic [1:0] {
        FLD_NONE   = 2'd0,
        FLD_COEF_A = 2'd1,
        FLD_COEF_B = 2'd2,
        FLD_THRESH = 2'd3
    } cfg_field_e;

    // Which register group a write address falls into, for nb bands.
    function automatic cfg_field_e field_of(input int unsigned addr, input int unsigned nb);
        if (addr < nb)               return FLD_COEF_A;
        else if (addr < 2 * nb)      return FLD_COEF_B;
        else if (addr < 3 * nb - 1)  return FLD_THRESH;
        else                         return FLD_NONE;
    endfunction

    // Entry index inside the register group selected by field_of.
    function automatic int unsigned index_of(input int unsigned addr, input int unsigned nb);
        if (addr < nb)               return addr;
        else if (addr < 2 * nb)      return addr - nb;
        else if (addr < 3 * nb - 1)  return addr - 2 * nb;
        else                         return 0;
    endfunction

endpackage

// File: rtl/mfe_cfg_bank.sv
// Coefficient and threshold register bank with a legality check.
// Holds NUM_BANDS (a, b) pairs and NUM_BANDS-1 flux thresholds.
// Any write that would leave a pair with |b| > |a| is dropped, and cfg_err
// pulses in the following cycle.
// Assumes that software keeps the thresholds in ascending order.
module mfe_cfg_bank
    import mfe_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int FRAC_W     = 16,
    parameter int NUM_BANDS  = 5,
    parameter int CFG_ADDR_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [CFG_ADDR_W-1:0]    cfg_addr,
    input  logic [DATA_W-1:0]        cfg_wdata,
    output logic signed [DATA_W-1:0] coef_a [NUM_BANDS],
    output logic signed [DATA_W-1:0] coef_b [NUM_BANDS],
    output logic signed [DATA_W-1:0] thresh [NUM_BANDS-1],
    output logic                     cfg_err
);

    localparam int NUM_TH = NUM_BANDS - 1;
    localparam int MAG_W  = DATA_W + 1;
    localparam logic signed [DATA_W-1:0] UNITY = DATA_W'(1) <<< FRAC_W;

    // Magnitude widened by one bit so that the most negative value is exact.
    function automatic logic [MAG_W-1:0] mag(input logic [DATA_W-1:0] v);
        logic [MAG_W-1:0] ext;
        ext = {v[DATA_W-1], v};
        return v[DATA_W-1] ? (~ext + 1'b1) : ext;
    endfunction

    cfg_field_e     fld;
    int unsigned    fidx;
    logic [NUM_BANDS-1:0] hit_a, hit_b, rej_a, rej_b;
    logic [NUM_TH-1:0]    hit_t;
    logic           reject;

    // Decode the write address into a register group and an entry index.
    always_comb begin
        fld  = field_of(32'(cfg_addr), NUM_BANDS);
        fidx = index_of(32'(cfg_addr), NUM_BANDS);
    end

    for (genvar k = 0; k < NUM_BANDS; k++) begin : g_pair
        // Detect writes to this pair and whether they would break |b| <= |a|.
        always_comb begin
            hit_a[k] = cfg_we && (fld == FLD_COEF_A) && (fidx == k);
            hit_b[k] = cfg_we && (fld == FLD_COEF_B) && (fidx == k);
            rej_a[k] = hit_a[k] && (mag(cfg_wdata) < mag(coef_b[k]));
            rej_b[k] = hit_b[k] && (mag(cfg_wdata) > mag(coef_a[k]));
        end

        // Coefficient storage for this pair; legal writes only.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                coef_a[k] <= UNITY;
                coef_b[k] <= '0;
            end else begin
                if (hit_a[k] && !rej_a[k]) coef_a[k] <= cfg_wdata;
                if (hit_b[k] && !rej_b[k]) coef_b[k] <= cfg_wdata;
            end
        end

        AST_PAIR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
            mag(coef_b[k]) <= mag(coef_a[k])); // R7
        AST_REJ_A_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            rej_a[k] |=> $stable(coef_a[k])); // R7
        AST_REJ_B_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            rej_b[k] |=> $stable(coef_b[k])); // R7
    end

    for (genvar k = 0; k < NUM_TH; k++) begin : g_thresh
        // Detect a write to this threshold.
        always_comb hit_t[k] = cfg_we && (fld == FLD_THRESH) && (fidx == k);

        // Threshold storage; default points are spread symmetrically in half-unit steps.
        always_ff @(posedge clk) begin
            if (!rst_n)        thresh[k] <= DATA_W'((2 * k - (NUM_TH - 1)) * (1 <<< (FRAC_W - 1)));
            else if (hit_t[k]) thresh[k] <= cfg_wdata;
        end
    end

    // Merge the per-entry rejection flags.
    always_comb reject = (|rej_a) || (|rej_b);

    // One-cycle error pulse after a refused write.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_err <= 1'b0;
        else        cfg_err <= reject;
    end

    AST_REJECT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> cfg_err); // R7
    AST_UNMAPPED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && fld == FLD_NONE) |=> !cfg_err); // R6

endmodule

// File: rtl/mfe_flux_acc.sv
// Saturating flux integrator. On each valid sample the input, scaled by
// 2^-DT_SHIFT, is added to the flux register. The sum is clamped to the
// signed DATA_W range rather than wrapped. Assumes DT_SHIFT < DATA_W.
module mfe_flux_acc #(
    parameter int DATA_W   = 32,
    parameter int DT_SHIFT = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     x_valid,
    input  logic signed [DATA_W-1:0] x_in,
    output logic signed [DATA_W-1:0] phi
);

    localparam int SUM_W = DATA_W + 1;

    logic signed [DATA_W-1:0] step;
    logic signed [SUM_W-1:0]  sum;
    logic signed [DATA_W-1:0] phi_next;

    // Scale the sample by the time step and form the clamped next flux.
    always_comb begin
        step = x_in >>> DT_SHIFT;
        sum  = SUM_W'(phi) + SUM_W'(step);
        if (sum[SUM_W-1] != sum[SUM_W-2])
            phi_next = sum[SUM_W-1] ? {1'b1, {(DATA_W-1){1'b0}}} : {1'b0, {(DATA_W-1){1'b1}}};
        else
            phi_next = sum[DATA_W-1:0];
    end

    // Flux register; advances only on valid samples.
    always_ff @(posedge clk) begin
        if (!rst_n)       phi <= '0;
        else if (x_valid) phi <= phi_next;
    end

    AST_FLUX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !x_valid |=> $stable(phi)); // R3
    AST_FLUX_NO_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (x_valid && !x_in[DATA_W-1]) |=> (phi >= $past(phi))); // R9
    AST_FLUX_NO_WRAP_DN: assert property (@(posedge clk) disable iff (!rst_n)
        (x_valid && x_in[DATA_W-1]) |=> (phi <= $past(phi))); // R9

endmodule

// File: rtl/mfe_band_sel.sv
// Flux band classifier: counts how many thresholds the flux has reached.
// The count is a band index in 0..NUM_BANDS-1 when the thresholds are
// ascending. It is still a valid index when they are not.
module mfe_band_sel #(
    parameter int DATA_W    = 32,
    parameter int NUM_BANDS = 5,
    parameter int BAND_W    = $clog2(NUM_BANDS)
) (
    input  logic signed [DATA_W-1:0] phi,
    input  logic signed [DATA_W-1:0] thresh [NUM_BANDS-1],
    output logic [BAND_W-1:0]        band
);

    localparam int NUM_TH = NUM_BANDS - 1;

    logic [NUM_TH-1:0] at_or_above;

    for (genvar k = 0; k < NUM_TH; k++) begin : g_cmp
        // Signed comparison of the flux against one threshold.
        always_comb at_or_above[k] = (phi >= thresh[k]);
    end

    // Population count of the comparator outputs.
    always_comb begin
        band = '0;
        for (int k = 0; k < NUM_TH; k++) band = band + BAND_W'(at_or_above[k]);
    end

endmodule

// File: rtl/mfe_slope_mult.sv
// Forms slope = a + b or a - b, with the sign chosen by phi_neg. Multiplies
// the sample by the slope, rescales from Q(2F) to QF, saturates, and
// registers the result. y_valid follows x_valid by one cycle, and y_out
// holds between samples. Assumes a and b are already legal (|b| <= |a|).
module mfe_slope_mult #(
    parameter int DATA_W = 32,
    parameter int FRAC_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     x_valid,
    input  logic signed [DATA_W-1:0] x_in,
    input  logic signed [DATA_W-1:0] coef_a,
    input  logic signed [DATA_W-1:0] coef_b,
    input  logic                     phi_neg,
    output logic signed [DATA_W-1:0] y_out,
    output logic                     y_valid
);

    localparam int SLOPE_W = DATA_W + 2;
    localparam int PROD_W  = DATA_W + SLOPE_W;

    logic signed [SLOPE_W-1:0] slope;
    logic signed [PROD_W-1:0]  prod;
    logic signed [PROD_W-1:0]  scaled;
    logic signed [DATA_W-1:0]  y_next;

    // Slope, product and clamp to the output range.
    always_comb begin
        slope  = phi_neg ? (SLOPE_W'(coef_a) - SLOPE_W'(coef_b))
                         : (SLOPE_W'(coef_a) + SLOPE_W'(coef_b));
        prod   = PROD_W'(x_in) * PROD_W'(slope);
        scaled = prod >>> FRAC_W;
        if ((&scaled[PROD_W-1:DATA_W-1]) || !(|scaled[PROD_W-1:DATA_W-1]))
            y_next = scaled[DATA_W-1:0];
        else
            y_next = scaled[PROD_W-1] ? {1'b1, {(DATA_W-1){1'b0}}} : {1'b0, {(DATA_W-1){1'b1}}};
    end

    // Output register and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_out   <= '0;
            y_valid <= 1'b0;
        end else begin
            y_valid <= x_valid;
            if (x_valid) y_out <= y_next;
        end
    end

    AST_Y_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        x_valid |=> y_valid); // R2
    AST_Y_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !x_valid |=> (!y_valid && $stable(y_out))); // R2
    AST_ZERO_IN_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (x_valid && x_in == '0) |=> (y_out == '0)); // R4

endmodule

// File: rtl/memristor_flux_emu.sv
// Top level of the flux-controlled multistate memristor emulator.
// It ties together the configuration bank, flux integrator, band
// classifier and slope multiplier. The pair used for a sample is chosen
// from the flux before that sample is added. In two-state mode pair 0 is
// always used. In five-state mode the flux band picks the pair.
module memristor_flux_emu #(
    parameter int DATA_W     = 32,
    parameter int FRAC_W     = 16,
    parameter int DT_SHIFT   = 4,
    parameter int NUM_BANDS  = 5,
    parameter int CFG_ADDR_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mode_five,
    input  logic                     x_valid,
    input  logic signed [DATA_W-1:0] x_in,
    input  logic                     cfg_we,
    input  logic [CFG_ADDR_W-1:0]    cfg_addr,
    input  logic [DATA_W-1:0]        cfg_wdata,
    output logic signed [DATA_W-1:0] y_out,
    output logic                     y_valid,
    output logic                     cfg_err
);

    localparam int BAND_W = $clog2(NUM_BANDS);

    logic signed [DATA_W-1:0] coef_a [NUM_BANDS];
    logic signed [DATA_W-1:0] coef_b [NUM_BANDS];
    logic signed [DATA_W-1:0] thresh [NUM_BANDS-1];
    logic signed [DATA_W-1:0] phi;
    logic [BAND_W-1:0]        band;
    logic [BAND_W-1:0]        sel;
    logic signed [DATA_W-1:0] a_sel, b_sel;

    mfe_cfg_bank #(
        .DATA_W(DATA_W), .FRAC_W(FRAC_W), .NUM_BANDS(NUM_BANDS), .CFG_ADDR_W(CFG_ADDR_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .coef_a(coef_a), .coef_b(coef_b),
        .thresh(thresh), .cfg_err(cfg_err)
    );

    mfe_flux_acc #(.DATA_W(DATA_W), .DT_SHIFT(DT_SHIFT)) u_flux (
        .clk(clk), .rst_n(rst_n), .x_valid(x_valid), .x_in(x_in), .phi(phi)
    );

    mfe_band_sel #(.DATA_W(DATA_W), .NUM_BANDS(NUM_BANDS), .BAND_W(BAND_W)) u_band (
        .phi(phi), .thresh(thresh), .band(band)
    );

    // Pick the coefficient pair for the current mode.
    always_comb begin
        sel   = mode_five ? band : '0;
        a_sel = coef_a[sel];
        b_sel = coef_b[sel];
    end

    mfe_slope_mult #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_mult (
        .clk(clk), .rst_n(rst_n), .x_valid(x_valid), .x_in(x_in),
        .coef_a(a_sel), .coef_b(b_sel), .phi_neg(phi[DATA_W-1]),
        .y_out(y_out), .y_valid(y_valid)
    );

    AST_BAND_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(band) < NUM_BANDS); // R5

endmodule

// File: tb/memristor_flux_emu_bench.sv
// Self-checking bench: directed corner cases followed by seeded random stimulus.
module memristor_flux_emu_bench;

    localparam int DT = 4;
    localparam longint ONE = 64'sd65536;
    localparam longint MAXV = 64'sd2147483647;
    localparam longint MINV = -64'sd2147483648;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_five = 1'b0;
    logic        x_valid = 1'b0;
    logic [31:0] x_in = '0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic signed [31:0] y_out;
    logic        y_valid;
    logic        cfg_err;

    int n_checks = 0;
    int n_fails  = 0;

    // Bench model state
    longint m_a [5];
    longint m_b [5];
    longint m_t [4];
    longint m_phi;
    bit     m_mode;

    always #2.5 clk = ~clk;

    memristor_flux_emu u_memristor_flux_emu (
        .clk(clk), .rst_n(rst_n), .mode_five(mode_five), .x_valid(x_valid),
        .x_in(x_in), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .y_out(y_out), .y_valid(y_valid), .cfg_err(cfg_err)
    );

    function automatic longint sat32(input longint v);
        if (v > MAXV) return MAXV;
        if (v < MINV) return MINV;
        return v;
    endfunction

    function automatic longint absl(input longint v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic int band_of(input longint p);
        int n = 0;
        for (int k = 0; k < 4; k++) if (p >= m_t[k]) n++;
        return n;
    endfunction

    function automatic longint expect_y(input longint x);
        int     i;
        longint slope;
        i = m_mode ? band_of(m_phi) : 0;
        slope = (m_phi < 0) ? (m_a[i] - m_b[i]) : (m_a[i] + m_b[i]);
        return sat32((x * slope) >>> 16);
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 5; k++) begin m_a[k] = ONE; m_b[k] = 0; end
        m_t[0] = -98304; m_t[1] = -32768; m_t[2] = 32768; m_t[3] = 98304;
        m_phi = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; x_valid = 1'b0; cfg_we = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
        check(y_out == 0, "R1 y_out", longint'(y_out), 0);
        check(y_valid == 1'b0, "R1 y_valid", longint'(y_valid), 0);
        check(cfg_err == 1'b0, "R1 cfg_err", longint'(cfg_err), 0);
    endtask

    // One write; the model decides acceptance and the error pulse is checked.
    task automatic cfg_wr(input int addr, input int data, input string req);
        bit     rej = 1'b0;
        longint d = longint'(data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'(addr); cfg_wdata = data;
        if (addr < 5) begin
            if (absl(d) < absl(m_b[addr])) rej = 1'b1; else m_a[addr] = d;
        end else if (addr < 10) begin
            if (absl(d) > absl(m_a[addr-5])) rej = 1'b1; else m_b[addr-5] = d;
        end else if (addr < 14) begin
            m_t[addr-10] = d;
        end
        @(negedge clk);
        cfg_we = 1'b0;
        check(cfg_err == rej, req, longint'(cfg_err), longint'(rej));
    endtask

    // One sample; output checked one clock after the strobe, idle checked after that.
    task automatic sample(input int x, input bit mode, input string req);
        longint exp;
        longint y_hold;
        @(negedge clk);
        mode_five = mode; x_valid = 1'b1; x_in = x;
        m_mode = mode;
        exp = expect_y(longint'(x));
        m_phi = sat32(m_phi + (longint'(x) >>> DT));
        @(negedge clk);
        x_valid = 1'b0;
        check(y_valid == 1'b1, {req, " y_valid"}, longint'(y_valid), 1);
        check(longint'(y_out) == exp, req, longint'(y_out), exp);
        y_hold = longint'(y_out);
        @(negedge clk);
        check(y_valid == 1'b0 && longint'(y_out) == y_hold, "R2 idle hold",
              longint'(y_out), y_hold);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        do_reset();                                      // R1

        // R1 default slope 1.0 and zero flux
        sample(32'h0003_0000, 1'b0, "R1 default pair");
        sample(32'hFFFE_0000, 1'b0, "R1 default pair neg");

        // R4 two-state hysteresis: a0=2.0, b0=0.5
        cfg_wr(0, 32'h0002_0000, "R7 accept a0");
        cfg_wr(5, 32'h0000_8000, "R7 accept b0");
        for (int i = 0; i < 4; i++) sample(32'h0004_0000, 1'b0, "R4 positive flux");
        for (int i = 0; i < 8; i++) sample(32'hFFFC_0000, 1'b0, "R4 flux to negative");
        sample(32'h0001_0000, 1'b0, "R4 negative flux branch");
        sample(32'h0000_0000, 1'b0, "R3 zero sample");

        // R7 rejections and boundary acceptance
        cfg_wr(5, 32'h0003_0000, "R7 reject b above a");
        cfg_wr(0, 32'h0000_4000, "R7 reject a below b");
        cfg_wr(5, 32'hFFFE_0000, "R7 accept |b|=|a|");
        sample(32'h0001_0000, 1'b0, "R7 pair after rejects");
        cfg_wr(5, 32'h0000_8000, "R7 restore b0");

        // R6 unmapped address has no effect
        cfg_wr(15, 32'h7FFF_FFFF, "R6 unmapped write");
        cfg_wr(14, 32'h0000_0001, "R6 unmapped write 14");
        sample(32'h0002_0000, 1'b0, "R6 output unchanged");

        // R5 five-state bands with distinct pairs
        do_reset();
        for (int k = 0; k < 5; k++) cfg_wr(k, (k + 1) * 65536, "R6 write a_k");
        for (int k = 0; k < 5; k++) cfg_wr(5 + k, (k + 1) * 8192, "R6 write b_k");
        for (int i = 0; i < 14; i++) sample(32'h0004_0000, 1'b1, "R5 rising flux");
        for (int i = 0; i < 28; i++) sample(32'hFFFC_0000, 1'b1, "R5 falling flux");
        cfg_wr(10, 32'hFFFD_0000, "R6 write t0");
        for (int i = 0; i < 6; i++) sample(32'h0002_0000, 1'b1, "R5 moved threshold");
        sample(32'h0002_0000, 1'b0, "R4 mode back to two-state");

        // R8 / R9 saturation
        do_reset();
        cfg_wr(0, 32'h4000_0000, "R7 accept big a0");
        cfg_wr(5, 32'h4000_0000, "R7 accept b0 equal a0");
        for (int i = 0; i < 20; i++) sample(32'h7FFF_FFFF, 1'b0, "R8 positive saturation");
        sample(32'h7FFF_FFFF, 1'b0, "R9 flux held at max");
        sample(32'hFFFF_0000, 1'b0, "R8 negative saturation");
        sample(32'h0001_0000, 1'b0, "R9 flux did not wrap");

        // Random phase
        do_reset();
        for (int i = 0; i < 400; i++) begin
            int r = int'($urandom_range(0, 9));
            if (r == 0) begin
                int addr = int'($urandom_range(0, 9));
                int val  = int'($urandom_range(0, 32'h0008_0000)) - 32'h0004_0000;
                cfg_wr(addr, val, "R7 random write");
            end else begin
                int  x = int'($urandom_range(0, 32'h0010_0000)) - 32'h0008_0000;
                bit  m = ($urandom_range(0, 1) == 1);
                sample(x, m, m ? "R5 random" : "R4 random");
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule